// File: doc/BRIEF.md
# Low-Frequency Crystal Pin Role and Power Controller

This block decides what the two pins shared with a low-frequency crystal do, and whether the crystal oscillator's analog core gets power. It reads a function-select bit for the crystal input pin, a bypass bit, the source-select fields of three clock outputs, and three run-state bits. These are the oscillator-off bit for the auxiliary clock, the processor-off bit for the main clock, and the peripheral-clock-off bit for the subsystem clock. Each pin gets a role: general-purpose I/O, crystal terminal, or external square-wave clock input.

A clock output asks for the crystal only while it has the crystal selected and its run-state bit lets it run. Power reaches the oscillator only when one of these asks is active and the pins are wired for a real crystal. In bypass, the oscillator stays powered down and the input pin takes the external clock. All outputs are registered on the system clock. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `xosc_pin_ctrl`

## Requirements
- R1: With `in_pin_fsel` low, both pin modes are general-purpose I/O (code 2'b00) and `osc_power_en` is low, whatever the other inputs are.
- R2: With `in_pin_fsel` high and `bypass` low, both pin modes are crystal (code 2'b01).
- R3: With `in_pin_fsel` and `bypass` both high, `in_pin_mode` is external clock input (code 2'b10), `out_pin_mode` is general-purpose I/O (2'b00), and `osc_power_en` is low.
- R4: `out_pin_fsel` has no effect on any output.
- R5: `osc_request` is high when `aclk_sel` equals 0 (crystal code) and `osc_off` is low. It is low when none of the three clocks meets its own condition.
- R6: `osc_request` is high when `mclk_sel` equals 0 and `cpu_off` is low.
- R7: `osc_request` is high when `smclk_sel` equals 0 and `smclk_off` is low.
- R8: `osc_power_en` is high exactly when `osc_request` would be high and the pins are in crystal mode (R2).
- R9: Every output shows the inputs sampled at the previous rising clock edge. A change in an input does not show before the next rising edge.
- R10: While `rst_n` is low, the outputs are 2'b00, 2'b00, 0, 0. After `rst_n` rises, they keep these values through the second rising edge and follow the inputs from the third.
- R11: With every select at 0, all run-state bits low and `in_pin_fsel` low (the power-up setting), `osc_request` is high but `osc_power_en` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pin_fsel | input | 1 | Function select of the crystal input pin |
| out_pin_fsel | input | 1 | Function select of the crystal output pin (no effect) |
| bypass | input | 1 | External clock on the input pin, oscillator off |
| aclk_sel | input | SEL_W | Auxiliary clock source select, 0 = crystal |
| mclk_sel | input | SEL_W | Main clock source select, 0 = crystal |
| smclk_sel | input | SEL_W | Subsystem clock source select, 0 = crystal |
| osc_off | input | 1 | Auxiliary clock stopped by run state |
| cpu_off | input | 1 | Main clock stopped by run state |
| smclk_off | input | 1 | Subsystem clock stopped by run state |
| in_pin_mode | output | 2 | Input pin role: 00 I/O, 01 crystal, 10 external clock |
| out_pin_mode | output | 2 | Output pin role: 00 I/O, 01 crystal |
| osc_power_en | output | 1 | Oscillator core power enable |
| osc_request | output | 1 | At least one clock asks for the crystal |

## Verification
The properties assume every input is synchronous to `clk` and holds steady across the rising edge at which it is sampled. The next-cycle checks are switched off until the synchronized reset has been released. The bench changes inputs only on the falling edge and samples one time unit after a rising edge. Every input transition therefore meets these assumptions, including the change checked just before the edge for R9.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

  typedef enum logic [1:0] {
    PIN_GPIO   = 2'b00,
    PIN_XTAL   = 2'b01,
    PIN_EXTCLK = 2'b10
  } pin_mode_e;

  typedef struct packed {
    pin_mode_e in_mode;
    pin_mode_e out_mode;
    logic      pwr_en;
    logic      req;
  } xosc_out_t;

  localparam xosc_out_t XOSC_OUT_RST = '{
    in_mode:  PIN_GPIO,
    out_mode: PIN_GPIO,
    pwr_en:   1'b0,
    req:      1'b0
  };

endpackage

// File: rtl/xosc_rst_sync.sv
module xosc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/xosc_pin_decode.sv
module xosc_pin_decode
  import xosc_pkg::*;
(
  input  logic      in_fsel,
  input  logic      bypass,
  output pin_mode_e in_mode,
  output pin_mode_e out_mode,
  output logic      xtal_mode
);

  always_comb begin
    xtal_mode = in_fsel & ~bypass;
    if (!in_fsel) begin
      in_mode  = PIN_GPIO;
      out_mode = PIN_GPIO;
    end else if (bypass) begin
      in_mode  = PIN_EXTCLK;
      out_mode = PIN_GPIO;
    end else begin
      in_mode  = PIN_XTAL;
      out_mode = PIN_XTAL;
    end
  end

endmodule

// File: rtl/xosc_demand.sv
module xosc_demand #(
  parameter int NUM_CLK   = 3,
  parameter int SEL_W     = 3,
  parameter int XTAL_CODE = 0
) (
  input  logic [NUM_CLK-1:0][SEL_W-1:0] sel,
  input  logic [NUM_CLK-1:0]            stop,
  output logic                          req
);

  localparam logic [SEL_W-1:0] CODE = SEL_W'(XTAL_CODE);

  logic [NUM_CLK-1:0] term;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_term
    assign term[g] = (sel[g] == CODE) & ~stop[g];
  end

  assign req = |term;

endmodule

// File: rtl/xosc_out_reg.sv
module xosc_out_reg
  import xosc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  xosc_out_t d,
  output xosc_out_t q
);

  xosc_out_t q_r;
  logic      ld_en;

  always_comb begin
    ld_en = (d != q_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= XOSC_OUT_RST;
    end else if (ld_en) begin
      q_r <= d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/xosc_pin_ctrl.sv
module xosc_pin_ctrl
  import xosc_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int XTAL_CODE   = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_pin_fsel,
  input  logic             out_pin_fsel,
  input  logic             bypass,
  input  logic [SEL_W-1:0] aclk_sel,
  input  logic [SEL_W-1:0] mclk_sel,
  input  logic [SEL_W-1:0] smclk_sel,
  input  logic             osc_off,
  input  logic             cpu_off,
  input  logic             smclk_off,
  output logic [1:0]       in_pin_mode,
  output logic [1:0]       out_pin_mode,
  output logic             osc_power_en,
  output logic             osc_request
);

  localparam int NUM_CLK = 3;

  logic                          rst_n_sync;
  logic [NUM_CLK-1:0][SEL_W-1:0] sel_vec;
  logic [NUM_CLK-1:0]            stop_vec;
  logic                          req_c;
  logic                          xtal_c;
  pin_mode_e                     in_mode_c;
  pin_mode_e                     out_mode_c;
  xosc_out_t                     nxt;
  xosc_out_t                     cur;
  logic                          unused_out_fsel;

  assign unused_out_fsel = out_pin_fsel;

  xosc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xosc_pin_decode u_pin_decode (
    .in_fsel   (in_pin_fsel),
    .bypass    (bypass),
    .in_mode   (in_mode_c),
    .out_mode  (out_mode_c),
    .xtal_mode (xtal_c)
  );

  assign sel_vec  = {smclk_sel, mclk_sel, aclk_sel};
  assign stop_vec = {smclk_off, cpu_off, osc_off};

  xosc_demand #(
    .NUM_CLK   (NUM_CLK),
    .SEL_W     (SEL_W),
    .XTAL_CODE (XTAL_CODE)
  ) u_demand (
    .sel  (sel_vec),
    .stop (stop_vec),
    .req  (req_c)
  );

  always_comb begin
    nxt.in_mode  = in_mode_c;
    nxt.out_mode = out_mode_c;
    nxt.req      = req_c;
    nxt.pwr_en   = req_c & xtal_c;
  end

  xosc_out_reg u_out_reg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d     (nxt),
    .q     (cur)
  );

  assign in_pin_mode  = cur.in_mode;
  assign out_pin_mode = cur.out_mode;
  assign osc_power_en = cur.pwr_en;
  assign osc_request  = cur.req;

endmodule

// File: rtl/xosc_pin_ctrl_chk.sv
module xosc_pin_ctrl_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             in_pin_fsel,
  input logic             bypass,
  input logic [SEL_W-1:0] aclk_sel,
  input logic [SEL_W-1:0] mclk_sel,
  input logic [SEL_W-1:0] smclk_sel,
  input logic             osc_off,
  input logic             cpu_off,
  input logic             smclk_off,
  input logic [1:0]       in_pin_mode,
  input logic [1:0]       out_pin_mode,
  input logic             osc_power_en,
  input logic             osc_request
);

  assert_gpio_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_pin_fsel |=> (in_pin_mode == 2'b00) && (out_pin_mode == 2'b00) && !osc_power_en);

  assert_xtal_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_pin_fsel && !bypass) |=> (in_pin_mode == 2'b01) && (out_pin_mode == 2'b01));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_pin_fsel && bypass) |=> (in_pin_mode == 2'b10) && (out_pin_mode == 2'b00) && !osc_power_en);

  assert_aclk_req_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((aclk_sel == '0) && !osc_off) |=> osc_request);

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (((aclk_sel != '0) || osc_off) && ((mclk_sel != '0) || cpu_off) &&
     ((smclk_sel != '0) || smclk_off)) |=> !osc_request);

  assert_mclk_req_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((mclk_sel == '0) && !cpu_off) |=> osc_request);

  assert_smclk_req_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((smclk_sel == '0) && !smclk_off) |=> osc_request);

  assert_pwr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    osc_power_en |-> (osc_request && (in_pin_mode == 2'b01)));

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n_sync |-> (in_pin_mode == 2'b00) && (out_pin_mode == 2'b00) &&
                    !osc_power_en && !osc_request);

endmodule

bind xosc_pin_ctrl xosc_pin_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n_sync   (rst_n_sync),
  .in_pin_fsel  (in_pin_fsel),
  .bypass       (bypass),
  .aclk_sel     (aclk_sel),
  .mclk_sel     (mclk_sel),
  .smclk_sel    (smclk_sel),
  .osc_off      (osc_off),
  .cpu_off      (cpu_off),
  .smclk_off    (smclk_off),
  .in_pin_mode  (in_pin_mode),
  .out_pin_mode (out_pin_mode),
  .osc_power_en (osc_power_en),
  .osc_request  (osc_request)
);

// File: tb/test_xosc_pin_ctrl.sv
`timescale 1ns/1ps
module test_xosc_pin_ctrl;

  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_pin_fsel, out_pin_fsel, bypass;
  logic [SEL_W-1:0] aclk_sel, mclk_sel, smclk_sel;
  logic             osc_off, cpu_off, smclk_off;
  logic [1:0]       in_pin_mode, out_pin_mode;
  logic             osc_power_en, osc_request;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  xosc_pin_ctrl #(.SEL_W(SEL_W)) i_xosc_pin_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_pin_fsel  (in_pin_fsel),
    .out_pin_fsel (out_pin_fsel),
    .bypass       (bypass),
    .aclk_sel     (aclk_sel),
    .mclk_sel     (mclk_sel),
    .smclk_sel    (smclk_sel),
    .osc_off      (osc_off),
    .cpu_off      (cpu_off),
    .smclk_off    (smclk_off),
    .in_pin_mode  (in_pin_mode),
    .out_pin_mode (out_pin_mode),
    .osc_power_en (osc_power_en),
    .osc_request  (osc_request)
  );

  function automatic logic [5:0] expect_out();
    logic [1:0] e_in, e_out;
    logic       e_req, e_pwr;
    e_in  = !in_pin_fsel ? 2'b00 : (bypass ? 2'b10 : 2'b01);
    e_out = (in_pin_fsel && !bypass) ? 2'b01 : 2'b00;
    e_req = ((aclk_sel == 0) && !osc_off) || ((mclk_sel == 0) && !cpu_off) ||
            ((smclk_sel == 0) && !smclk_off);
    e_pwr = e_req && in_pin_fsel && !bypass;
    return {e_in, e_out, e_pwr, e_req};
  endfunction

  task automatic check(string tag, logic [5:0] exp_v);
    logic [5:0] act;
    act = {in_pin_mode, out_pin_mode, osc_power_en, osc_request};
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp_v);
    end
  endtask

  task automatic drive(logic f, logic of, logic byp, logic [SEL_W-1:0] a,
                       logic [SEL_W-1:0] m, logic [SEL_W-1:0] s,
                       logic oo, logic co, logic so);
    @(negedge clk);
    in_pin_fsel = f; out_pin_fsel = of; bypass = byp;
    aclk_sel = a; mclk_sel = m; smclk_sel = s;
    osc_off = oo; cpu_off = co; smclk_off = so;
  endtask

  task automatic step_check(string tag);
    logic [5:0] e;
    e = expect_out();
    @(posedge clk); #1;
    check(tag, e);
  endtask

  task automatic t_reset_R10();
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R10 held in reset", 6'b000000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 first edge after release", 6'b000000);
    @(posedge clk); #1;
    check("R10 second edge after release", 6'b000000);
    @(posedge clk); #1;
    check("R10 third edge follows inputs", 6'b010111);
  endtask

  task automatic t_powerup_R11();
    drive(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    step_check("R11 power-up default");
    check("R11 request high, power low", 6'b000001);
  endtask

  task automatic t_pins_R1_R3();
    drive(1'b0, 1'b1, 1'b1, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    step_check("R1 fsel clear with bypass");
    drive(1'b1, 1'b0, 1'b0, 3, 3, 0, 1'b0, 1'b0, 1'b0);
    step_check("R2 crystal mode");
    check("R2 crystal codes", 6'b010111);
    drive(1'b1, 1'b0, 1'b1, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    step_check("R3 bypass mode");
    check("R3 bypass codes", 6'b100001);
  endtask

  task automatic t_out_fsel_R4();
    for (int i = 0; i < 4; i++) begin
      drive(i[0], 1'b0, i[1], 0, 5, 5, 1'b0, 1'b0, 1'b0);
      step_check("R4 out_pin_fsel low");
      drive(i[0], 1'b1, i[1], 0, 5, 5, 1'b0, 1'b0, 1'b0);
      step_check("R4 out_pin_fsel high");
    end
  endtask

  task automatic t_demand_R5_R7();
    drive(1'b1, 1'b0, 1'b0, 0, 2, 7, 1'b0, 1'b0, 1'b0);
    step_check("R5 aux clock demand");
    drive(1'b1, 1'b0, 1'b0, 0, 2, 7, 1'b1, 1'b0, 1'b0);
    step_check("R5 aux stopped, idle");
    check("R5 idle gives no request", 6'b010100);
    drive(1'b1, 1'b0, 1'b0, 4, 0, 1, 1'b0, 1'b0, 1'b1);
    step_check("R6 main clock demand");
    drive(1'b1, 1'b0, 1'b0, 4, 0, 1, 1'b0, 1'b1, 1'b0);
    step_check("R6 main stopped");
    drive(1'b1, 1'b0, 1'b0, 6, 6, 0, 1'b1, 1'b1, 1'b0);
    step_check("R7 subsystem clock demand");
    drive(1'b1, 1'b0, 1'b0, 6, 6, 0, 1'b1, 1'b1, 1'b1);
    step_check("R7 subsystem stopped");
    drive(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b1, 1'b1, 1'b1);
    step_check("R5 R6 R7 all selected, all stopped");
  endtask

  task automatic t_gate_R8();
    for (int i = 0; i < 8; i++) begin
      drive(i[0], 1'b0, i[1], i[2] ? 3'd0 : 3'd1, 3'd2, 3'd3, 1'b0, 1'b0, 1'b0);
      step_check("R8 power gating");
    end
  endtask

  task automatic t_latency_R9();
    drive(1'b1, 1'b0, 1'b0, 0, 1, 1, 1'b0, 1'b0, 1'b0);
    step_check("R9 setup state");
    drive(1'b1, 1'b0, 1'b1, 1, 1, 1, 1'b0, 1'b0, 1'b0);
    #1;
    check("R9 no change before edge", 6'b010111);
    step_check("R9 change after edge");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_pin_fsel = 1'b0; out_pin_fsel = 1'b0; bypass = 1'b0;
    aclk_sel = '0; mclk_sel = '0; smclk_sel = '0;
    osc_off = 1'b0; cpu_off = 1'b0; smclk_off = 1'b0;
    t_reset_R10();
    t_powerup_R11();
    t_pins_R1_R3();
    t_out_fsel_R4();
    t_demand_R5_R7();
    t_gate_R8();
    t_latency_R9();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule